// File: doc/BRIEF.md
# DDR2 Read Burst Rule Monitor

This block is a passive observer placed on the command path between a memory controller and a DDR2 device. Each clock it looks at the command strobe, the command kind and the auto-precharge flag, together with the configured burst length and read latency. It keeps track of the most recent read burst and flags any command that cuts into that burst illegally, or any write that follows a read too soon for the bus to turn around.

The first rule break is held in a sticky flag with a code that says which rule was broken. It stays there until software-independent logic asserts a synchronous clear. Every rule break, including those that come after the first, also gives a one-clock error pulse. The monitor never drives the command bus, and it tracks no bank or row state.

Top module: `ddr2_rd_rule_mon`

## Requirements
- R1: After reset, `err_pulse` and `err_sticky` are low and `err_code` is 0.
- R2: When a READ with burst of four (`bl8`=0) is followed one clock later by any valid command, this is a violation with code 1.
- R3: When a READ with burst of eight (`bl8`=1) is followed 1, 2 or 3 clocks later by a valid command that is not a READ, this is a violation with code 2. Command kinds are 0 other, 1 READ, 2 WRITE and 3 PRECHARGE.
- R4: When a READ with burst of eight is followed 1 or 3 clocks later by a READ, the truncation is misaligned and gives code 3.
- R5: A READ that comes 2 clocks after a burst-of-eight READ is legal when that earlier READ had `cmd_ap`=0. It gives code 4 when that earlier READ had `cmd_ap`=1. Every READ restarts the burst window, so the window of a truncating READ is measured from that READ.
- R6: A READ issued exactly BL/2 clocks after the previous READ (2 for a burst of four, 4 for a burst of eight) is seamless and legal.
- R7: A WRITE issued after the read burst window has closed, but fewer than BL/2+2 clocks after the last READ, gives code 5. A WRITE at BL/2+2 clocks or later is legal for any value of `rd_lat`.
- R8: `err_pulse` is high for exactly the one clock that follows each violating command, and it is low in every other clock.
- R9: `err_code` holds the code of the first violation since the last clear. Later violations pulse `err_pulse` but leave `err_code` unchanged.
- R10: When `clr` is high at a clock edge, `err_sticky` and `err_code` are zero after that edge. This holds even when a violation happens in the same clock.
- R11: A clock with `cmd_vld` low is not a command, whatever the value of `cmd_kind`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of sticky flag and code |
| cmd_vld | input | 1 | A command is present this clock |
| cmd_kind | input | 2 | 0 other, 1 READ, 2 WRITE, 3 PRECHARGE |
| cmd_ap | input | 1 | Auto precharge requested with this command |
| bl8 | input | 1 | Burst length: 1 means eight, 0 means four |
| rd_lat | input | RL_W | Configured read latency in clocks |
| err_pulse | output | 1 | One-clock pulse per violation |
| err_sticky | output | 1 | First violation seen since clear |
| err_code | output | 3 | Code of the first violation, 0 when none |

## Verification
The assertions assume that `bl8` and `rd_lat` stay constant while a burst is in flight, and that a command is counted only in clocks where `cmd_vld` is high. The stimulus changes `bl8` only together with a new READ, and it changes `rd_lat` only between scenarios. Each scenario is separated by enough idle clocks to close both the burst window and the write turnaround window, so every expected pulse depends only on the commands that the scenario issues.

// File: rtl/ddr2_rd_rule_mon.sv
module ddr2_rd_rule_mon #(
  parameter int CNT_W = 4,
  parameter int RL_W  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            cmd_vld,
  input  logic [1:0]      cmd_kind,
  input  logic            cmd_ap,
  input  logic            bl8,
  input  logic [RL_W-1:0] rd_lat,
  output logic            err_pulse,
  output logic            err_sticky,
  output logic [2:0]      err_code
);
  localparam logic [1:0] K_READ  = 2'd1;
  localparam logic [1:0] K_WRITE = 2'd2;
  localparam int SW = ((CNT_W > RL_W) ? CNT_W : RL_W) + 2;

  logic             has_rd, cur_bl8, cur_ap;
  logic [CNT_W-1:0] gap;
  logic [2:0]       code_now;

  wire [CNT_W-1:0] half  = cur_bl8 ? CNT_W'(4) : CNT_W'(2);
  wire             busy  = has_rd && (gap < half);
  wire             is_rd = cmd_vld && (cmd_kind == K_READ);

  // write data starts RL-1 after WRITE; it must trail read data end (RL+BL/2) by one clock
  wire [SW-1:0] wr_data_at = SW'(gap) + SW'(rd_lat) - SW'(1);
  wire [SW-1:0] rd_free_at = SW'(rd_lat) + SW'(half) + SW'(1);
  wire          wr_ok      = !has_rd || (wr_data_at >= rd_free_at);

  always_comb begin
    code_now = 3'd0;
    if (cmd_vld) begin
      if (busy) begin
        if (!cur_bl8)              code_now = 3'd1;
        else if (cmd_kind != K_READ) code_now = 3'd2;
        else if (gap[0])           code_now = 3'd3;
        else if (cur_ap)           code_now = 3'd4;
      end else if (cmd_kind == K_WRITE && !wr_ok) begin
        code_now = 3'd5;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      has_rd  <= 1'b0;
      cur_bl8 <= 1'b0;
      cur_ap  <= 1'b0;
      gap     <= '0;
    end else if (is_rd) begin
      has_rd  <= 1'b1;
      cur_bl8 <= bl8;
      cur_ap  <= cmd_ap;
      gap     <= CNT_W'(1);
    end else if (has_rd && gap != '1) begin
      gap <= gap + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pulse  <= 1'b0;
      err_sticky <= 1'b0;
      err_code   <= 3'd0;
    end else begin
      err_pulse <= (code_now != 3'd0);
      if (clr) begin
        err_sticky <= 1'b0;
        err_code   <= 3'd0;
      end else if (!err_sticky && code_now != 3'd0) begin
        err_sticky <= 1'b1;
        err_code   <= code_now;
      end
    end
  end

  assert_bl4_cut_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_kind == K_READ && !bl8) ##1 cmd_vld |=> err_pulse);

  assert_write_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_kind == K_READ) ##1 (cmd_vld && cmd_kind == K_WRITE) |=> err_pulse);

  assert_sticky_pulses_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_sticky) |-> err_pulse);

  assert_first_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky && !clr) |=> (err_sticky && $stable(err_code)));

  assert_code_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |-> (err_code != 3'd0));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!err_sticky && err_code == 3'd0));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |=> !err_pulse);
endmodule

// File: tb/ddr2_rd_rule_mon_tb.sv
module ddr2_rd_rule_mon_tb_top;
  localparam int CLK_P = 10;
  localparam logic [1:0] OTH = 2'd0, RD = 2'd1, WR = 2'd2, PRE = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic cmd_vld = 1'b0, cmd_ap = 1'b0, bl8 = 1'b0;
  logic [1:0] cmd_kind = OTH;
  logic [3:0] rd_lat = 4'd5;
  logic err_pulse, err_sticky;
  logic [2:0] err_code;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit q_exp[$];
  string q_tag[$];

  always #(CLK_P/2) clk = ~clk;

  ddr2_rd_rule_mon dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cmd_vld(cmd_vld), .cmd_kind(cmd_kind),
    .cmd_ap(cmd_ap), .bl8(bl8), .rd_lat(rd_lat),
    .err_pulse(err_pulse), .err_sticky(err_sticky), .err_code(err_code)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [1:0] k, input bit ap, input bit b8,
                      input bit c, input bit exp, input string tag);
    @(negedge clk);
    cmd_vld = v; cmd_kind = k; cmd_ap = ap; bl8 = b8; clr = c;
    q_exp.push_back(exp);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, PRE, 1'b0, bl8, 1'b0, 1'b0, tag);
  endtask

  task automatic clear_all();
    step(1'b0, OTH, 1'b0, bl8, 1'b1, 1'b0, "R10");
    idle(1, "R10");
    check("R10 sticky cleared", int'(err_sticky), 0);
    check("R10 code cleared", int'(err_code), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    #(CLK_P/4);
    if (q_exp.size() > 0) begin
      bit e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check({t, " err_pulse"}, int'(err_pulse), int'(e));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    #(CLK_P/4);
    check("R1 pulse in reset", int'(err_pulse), 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    check("R1 sticky after reset", int'(err_sticky), 0);
    check("R1 code after reset", int'(err_code), 0);
    check("R1 pulse after reset", int'(err_pulse), 0);

    // R6 seamless reads
    step(1, RD, 0, 1, 0, 0, "R6"); idle(3, "R6"); step(1, RD, 0, 1, 0, 0, "R6");
    idle(3, "R6"); step(1, RD, 0, 0, 0, 0, "R6"); idle(1, "R6"); step(1, RD, 0, 0, 0, 0, "R6");
    idle(8, "R6");
    check("R6 no violation", int'(err_sticky), 0);

    // R2 burst of four interrupted
    step(1, RD, 0, 0, 0, 0, "R2"); step(1, PRE, 0, 0, 0, 1, "R2"); idle(1, "R2");
    check("R2 code", int'(err_code), 1);
    check("R2 sticky", int'(err_sticky), 1);
    clear_all(); idle(8, "R2");

    // R3 non-read during burst of eight
    step(1, RD, 0, 1, 0, 0, "R3"); idle(1, "R3"); step(1, OTH, 0, 1, 0, 1, "R3"); idle(1, "R3");
    check("R3 code", int'(err_code), 2);
    clear_all(); idle(8, "R3");

    // R4 misaligned truncation at 1 and 3
    step(1, RD, 0, 1, 0, 0, "R4"); step(1, RD, 0, 1, 0, 1, "R4"); idle(1, "R4");
    check("R4 code dist1", int'(err_code), 3);
    clear_all(); idle(8, "R4");
    step(1, RD, 0, 1, 0, 0, "R4"); idle(2, "R4"); step(1, RD, 0, 1, 0, 1, "R4"); idle(1, "R4");
    check("R4 code dist3", int'(err_code), 3);
    clear_all(); idle(8, "R4");

    // R5 truncation of an auto-precharge burst, then legal truncation restarting the window
    step(1, RD, 1, 1, 0, 0, "R5"); idle(1, "R5"); step(1, RD, 0, 1, 0, 1, "R5"); idle(1, "R5");
    check("R5 code ap", int'(err_code), 4);
    clear_all(); idle(8, "R5");
    step(1, RD, 0, 1, 0, 0, "R5"); idle(1, "R5"); step(1, RD, 0, 1, 0, 0, "R5");
    idle(1, "R5"); step(1, PRE, 0, 1, 0, 1, "R5"); idle(1, "R5");
    check("R5 restarted window code", int'(err_code), 2);
    clear_all(); idle(8, "R5");

    // R7 write turnaround, across read latencies
    rd_lat = 4'd3;
    step(1, RD, 0, 0, 0, 0, "R7"); idle(2, "R7"); step(1, WR, 0, 0, 0, 1, "R7"); idle(1, "R7");
    check("R7 code bl4 early", int'(err_code), 5);
    clear_all(); idle(8, "R7");
    step(1, RD, 0, 0, 0, 0, "R7"); idle(3, "R7"); step(1, WR, 0, 0, 0, 0, "R7"); idle(1, "R7");
    check("R7 bl4 on time", int'(err_sticky), 0);
    idle(8, "R7");
    rd_lat = 4'd7;
    step(1, RD, 0, 1, 0, 0, "R7"); idle(4, "R7"); step(1, WR, 0, 1, 0, 1, "R7"); idle(1, "R7");
    check("R7 code bl8 early", int'(err_code), 5);
    clear_all(); idle(8, "R7");
    step(1, RD, 0, 1, 0, 0, "R7"); idle(5, "R7"); step(1, WR, 0, 1, 0, 0, "R7"); idle(1, "R7");
    check("R7 bl8 on time", int'(err_sticky), 0);
    idle(8, "R7");
    rd_lat = 4'd5;

    // R9 first code held
    step(1, RD, 0, 0, 0, 0, "R9"); step(1, PRE, 0, 0, 0, 1, "R9"); idle(8, "R9");
    step(1, RD, 0, 1, 0, 0, "R9"); step(1, PRE, 0, 1, 0, 1, "R9"); idle(1, "R9");
    check("R9 first code kept", int'(err_code), 1);
    clear_all(); idle(8, "R9");

    // R10 clear wins over same-clock violation
    step(1, RD, 0, 0, 0, 0, "R10"); step(1, PRE, 0, 0, 1, 1, "R10"); idle(1, "R10");
    check("R10 clear wins sticky", int'(err_sticky), 0);
    check("R10 clear wins code", int'(err_code), 0);
    idle(8, "R10");

    // R11 invalid strobe ignored
    step(1, RD, 0, 0, 0, 0, "R11"); step(0, PRE, 0, 0, 0, 0, "R11"); idle(1, "R11");
    check("R11 sticky", int'(err_sticky), 0);
    idle(3, "R8");
    wait (q_exp.size() == 0);
    @(negedge clk);
    finish_run();
  end
endmodule